// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block behaves like a small serial NOR flash memory on an SPI bus, with the block as the slave. A master lowers chip select and clocks in a one-byte opcode. For most commands a 24-bit address follows. The block supports four commands:

- write enable
- sector erase
- single-byte page program
- continuous read

Erase and program run only after a write-enable latch has been armed by an earlier frame. Each of them then starts a busy window of its own length, counted in system-clock cycles. While the window runs, the device turns away every new frame.

The storage is a small on-chip byte array. Its sector, page and byte fields still sit at their usual places in the 24-bit address. The number of sectors, the pages per sector and the bytes per page are set by width parameters. The serial pins are sampled by the fast system clock, so all internal logic stays in one clock domain.

The command decoder is a state machine with these states:

- **Idle**: chip select is high.
- **Opcode**: the first byte is being received.
- **Address**: the 24 address bits are being received.
- **ProgData**: the program data byte is being received.
- **ReadData**: data is streaming out to the master.
- **Hold**: a complete command is waiting for chip select to rise.
- **Ignore**: the frame is rejected.

Its transitions are:

- Idle→Opcode on a select fall, when the device is idle and the select gap was long enough.
- Idle→Ignore on a select fall otherwise.
- Opcode→Hold after write enable.
- Opcode→Address after erase, program or read.
- Opcode→Ignore after an unknown opcode.
- Address→Hold after the erase address.
- Address→ProgData after the program address.
- Address→ReadData after the read address.
- ProgData→Hold after the data byte.
- Hold→Ignore on any further clock.
- Any state→Idle when chip select rises.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the data output is high and every array byte reads 0xFF. The data output is high whenever no read data is being shifted.
- R2: The bus runs in SPI mode 3. Input bits are taken on the rising serial clock edge, MSB first. Output bits change only after a falling serial clock edge, or go high when chip select rises.
- R3: Opcode 0x06, in a frame of exactly 8 bits, arms the write-enable latch when chip select rises. Erase and program take effect only if the latch was armed by an earlier frame.
- R4: A program frame sent while the latch is clear leaves the array unchanged.
- R5: Opcode 0x02 is followed by 3 address bytes and 1 data byte, 40 bits in all. It writes old AND data at the addressed byte, so a program can only clear bits.
- R6: Opcode 0xD8 is followed by 3 address bytes, 32 bits in all. It sets every byte of the addressed sector to 0xFF, ignores the page and byte fields, and leaves other sectors untouched.
- R7: Opcode 0x03 is followed by 3 address bytes. Data bytes then stream out for as long as chip select is low. The address increments after each byte and wraps from the last array byte to byte 0.
- R8: A command takes effect only when chip select rises exactly at the end of its own frame length. A frame that is too long or too short changes nothing and leaves the latch as it was. The latch clears when an erase or program starts.
- R9: Erase starts a busy window of ERASE_CYC cycles, and program starts one of PROG_CYC cycles. Any frame that begins inside the window, including a read, is ignored, and its output stays at all ones.
- R10: A frame is ignored when chip select was high for fewer than MIN_CS_HIGH cycles before it fell.
- R11: Address fields sit at fixed bit positions: byte field from bit 0, page field from bit 8, sector field from bit 16. Only the low BY_W, PG_W and SEC_W bits of each field select storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master, idles high |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
Reads are tried from a fresh array, from a single programmed byte, and from a run that crosses the top of the array. Together these separate correct bit order and edge timing from address increment and wrap-around. Programs are sent with and without a prior write enable, with the exact length and with one extra byte, and with a select gap that is too short. These cases show whether the latch gates, clears and survives as required. An erase whose address has its page and byte fields set shows that only the sector field counts. Frames are placed inside the program window and inside the longer erase window, and a read after the program length has passed but during an erase must still be refused. This shows that the two busy lengths are distinct.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_PROG_DATA,
        ST_READ_DATA,
        ST_HOLD,
        ST_IGNORE
    } fsm_state_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ERASE = 8'hD8;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;

    localparam int BYTE_LSB   = 0;
    localparam int PAGE_LSB   = 8;
    localparam int SECTOR_LSB = 16;

    localparam logic [5:0] BITS_OPCODE = 6'd7;
    localparam logic [5:0] BITS_ADDR   = 6'd31;
    localparam logic [5:0] BITS_PROG   = 6'd39;

endpackage

// File: rtl/flash_spi_front.sv
module flash_spi_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_high,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    // two-stage synchroniser for {cs_n, sck, mosi}, plus one history stage
    logic [2:0] sync1, sync2;
    logic       cs_d, sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 3'b110;
            sync2 <= 3'b110;
            cs_d  <= 1'b1;
            sck_d <= 1'b1;
        end else begin
            sync1 <= {cs_n_i, sck_i, mosi_i};
            sync2 <= sync1;
            cs_d  <= sync2[2];
            sck_d <= sync2[1];
        end
    end

    assign cs_high  = sync2[2];
    assign cs_fall  = cs_d & ~sync2[2];
    assign cs_rise  = ~cs_d & sync2[2];
    assign sck_rise = ~sck_d & sync2[1] & ~sync2[2];
    assign sck_fall = sck_d & ~sync2[1] & ~sync2[2];
    assign mosi_s   = sync2[0];
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int ERASE_CYC = 3000,
    parameter int PROG_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_go,
    input  logic prog_go,
    output logic busy
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (erase_go) begin
            remain <= CW'(ERASE_CYC);
        end else if (prog_go) begin
            remain <= CW'(PROG_CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int SEC_W = 2,
    parameter int PG_W  = 1,
    parameter int BY_W  = 3,
    localparam int OFF_W = PG_W + BY_W,
    localparam int IDX_W = SEC_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_data,
    input  logic             erase_go,
    input  logic [SEC_W-1:0] erase_sec,
    output logic             erasing
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       mem [DEPTH];
    logic [SEC_W-1:0] er_sec;
    logic [OFF_W-1:0] er_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
            erasing <= 1'b0;
            er_sec  <= '0;
            er_off  <= '0;
        end else begin
            if (erase_go) begin
                erasing <= 1'b1;
                er_sec  <= erase_sec;
                er_off  <= '0;
            end else if (erasing) begin
                // walk one byte of the sector per cycle
                mem[{er_sec, er_off}] <= 8'hFF;
                er_off <= er_off + 1'b1;
                if (er_off == {OFF_W{1'b1}}) begin
                    erasing <= 1'b0;
                end
            end
            if (prog_en) begin
                mem[prog_idx] <= mem[prog_idx] & prog_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_pkg::*;
#(
    parameter int SEC_W       = 2,
    parameter int PG_W        = 1,
    parameter int BY_W        = 3,
    parameter int MIN_CS_HIGH = 25,
    localparam int IDX_W = SEC_W + PG_W + BY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_high,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             mosi_s,
    input  logic             busy,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             miso,
    output logic             prog_go,
    output logic [IDX_W-1:0] prog_idx,
    output logic [7:0]       prog_data,
    output logic             erase_go,
    output logic [SEC_W-1:0] erase_sec,
    output logic             wren_set,
    output logic             wel
);
    localparam int GW = $clog2(MIN_CS_HIGH + 1);

    fsm_state_t       st, nxt;
    logic [5:0]       bits;
    logic [6:0]       shin;
    logic [7:0]       op;
    logic [23:0]      addr;
    logic [7:0]       tx;
    logic [IDX_W-1:0] rd_ptr;
    logic [GW-1:0]    gap;

    logic [7:0]       byte_in;
    logic [23:0]      addr_full;
    logic [IDX_W-1:0] idx_full, idx_hold;
    logic             gap_ok;
    logic             commit_wren, commit_erase, commit_prog;
    logic             unused_addr_bits;

    assign byte_in   = {shin, mosi_s};
    assign addr_full = {addr[22:0], mosi_s};
    assign idx_full  = {addr_full[SECTOR_LSB +: SEC_W], addr_full[PAGE_LSB +: PG_W],
                        addr_full[BYTE_LSB +: BY_W]};
    assign idx_hold  = {addr[SECTOR_LSB +: SEC_W], addr[PAGE_LSB +: PG_W],
                        addr[BYTE_LSB +: BY_W]};
    assign unused_addr_bits = ^addr_full;
    assign gap_ok    = (gap == GW'(MIN_CS_HIGH));
    assign rd_idx    = (st == ST_ADDR) ? idx_full : rd_ptr;

    assign commit_wren  = (st == ST_HOLD) && cs_rise && (op == OP_WREN);
    assign commit_erase = (st == ST_HOLD) && cs_rise && (op == OP_ERASE) && wel && !busy;
    assign commit_prog  = (st == ST_HOLD) && cs_rise && (op == OP_PROG) && wel && !busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cs_fall) begin
                    nxt = (busy || !gap_ok) ? ST_IGNORE : ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                if (cs_rise) begin
                    nxt = ST_IDLE;
                end else if (sck_rise && bits == BITS_OPCODE) begin
                    case (byte_in)
                        OP_WREN:                    nxt = ST_HOLD;
                        OP_ERASE, OP_PROG, OP_READ: nxt = ST_ADDR;
                        default:                    nxt = ST_IGNORE;
                    endcase
                end
            end
            ST_ADDR: begin
                if (cs_rise) begin
                    nxt = ST_IDLE;
                end else if (sck_rise && bits == BITS_ADDR) begin
                    if (op == OP_PROG) begin
                        nxt = ST_PROG_DATA;
                    end else if (op == OP_READ) begin
                        nxt = ST_READ_DATA;
                    end else begin
                        nxt = ST_HOLD;
                    end
                end
            end
            ST_PROG_DATA: begin
                if (cs_rise) begin
                    nxt = ST_IDLE;
                end else if (sck_rise && bits == BITS_PROG) begin
                    nxt = ST_HOLD;
                end
            end
            ST_READ_DATA: begin
                if (cs_rise) nxt = ST_IDLE;
            end
            ST_HOLD: begin
                if (cs_rise) begin
                    nxt = ST_IDLE;
                end else if (sck_rise) begin
                    nxt = ST_IGNORE;
                end
            end
            ST_IGNORE: begin
                if (cs_rise) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wren_set  <= 1'b0;
            erase_go  <= 1'b0;
            prog_go   <= 1'b0;
            wel       <= 1'b0;
            gap       <= GW'(MIN_CS_HIGH);
            bits      <= '0;
            shin      <= '0;
            op        <= '0;
            addr      <= '0;
            prog_data <= 8'hFF;
            tx        <= 8'hFF;
            rd_ptr    <= '0;
            miso      <= 1'b1;
        end else begin
            wren_set <= commit_wren;
            erase_go <= commit_erase;
            prog_go  <= commit_prog;

            if (commit_wren) begin
                wel <= 1'b1;
            end else if (commit_erase || commit_prog) begin
                wel <= 1'b0;
            end

            if (!cs_high) begin
                gap <= '0;
            end else if (!gap_ok) begin
                gap <= gap + 1'b1;
            end

            if (st == ST_IDLE) begin
                bits <= '0;
            end else if (sck_rise) begin
                bits <= bits + 1'b1;
            end

            if (sck_rise) shin <= byte_in[6:0];

            if (st == ST_OPCODE && sck_rise && bits == BITS_OPCODE) op <= byte_in;
            if (st == ST_ADDR && sck_rise) addr <= addr_full;
            if (st == ST_PROG_DATA && sck_rise) prog_data <= byte_in;

            if (st == ST_ADDR && sck_rise && bits == BITS_ADDR && op == OP_READ) begin
                tx     <= rd_data;
                rd_ptr <= idx_full + 1'b1;
            end else if (st == ST_READ_DATA && sck_rise && bits[2:0] == 3'd7) begin
                tx     <= rd_data;
                rd_ptr <= rd_ptr + 1'b1;
            end

            if (cs_rise) begin
                miso <= 1'b1;
            end else if (st == ST_READ_DATA && sck_fall) begin
                miso <= tx[~bits[2:0]];
            end
        end
    end

    assign prog_idx  = idx_hold;
    assign erase_sec = addr[SECTOR_LSB +: SEC_W];
endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu #(
    parameter int SEC_W       = 2,
    parameter int PG_W        = 1,
    parameter int BY_W        = 3,
    parameter int ERASE_CYC   = 3000,
    parameter int PROG_CYC    = 1000,
    parameter int MIN_CS_HIGH = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int IDX_W = SEC_W + PG_W + BY_W;

    logic             cs_high_w, cs_fall_w, cs_rise_w, sck_rise_w, sck_fall_w, mosi_w;
    logic             busy_w, erasing_w;
    logic             prog_go_w, erase_go_w, wren_set_w, wel_w;
    logic [IDX_W-1:0] rd_idx_w, prog_idx_w;
    logic [7:0]       rd_data_w, prog_data_w;
    logic [SEC_W-1:0] erase_sec_w;

    flash_spi_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sck_i    (sck),
        .mosi_i   (mosi),
        .cs_high  (cs_high_w),
        .cs_fall  (cs_fall_w),
        .cs_rise  (cs_rise_w),
        .sck_rise (sck_rise_w),
        .sck_fall (sck_fall_w),
        .mosi_s   (mosi_w)
    );

    flash_cmd_fsm #(
        .SEC_W       (SEC_W),
        .PG_W        (PG_W),
        .BY_W        (BY_W),
        .MIN_CS_HIGH (MIN_CS_HIGH)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_high   (cs_high_w),
        .cs_fall   (cs_fall_w),
        .cs_rise   (cs_rise_w),
        .sck_rise  (sck_rise_w),
        .sck_fall  (sck_fall_w),
        .mosi_s    (mosi_w),
        .busy      (busy_w),
        .rd_data   (rd_data_w),
        .rd_idx    (rd_idx_w),
        .miso      (miso),
        .prog_go   (prog_go_w),
        .prog_idx  (prog_idx_w),
        .prog_data (prog_data_w),
        .erase_go  (erase_go_w),
        .erase_sec (erase_sec_w),
        .wren_set  (wren_set_w),
        .wel       (wel_w)
    );

    flash_busy_timer #(
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_go (erase_go_w),
        .prog_go  (prog_go_w),
        .busy     (busy_w)
    );

    flash_array #(
        .SEC_W (SEC_W),
        .PG_W  (PG_W),
        .BY_W  (BY_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx_w),
        .rd_data   (rd_data_w),
        .prog_en   (prog_go_w),
        .prog_idx  (prog_idx_w),
        .prog_data (prog_data_w),
        .erase_go  (erase_go_w),
        .erase_sec (erase_sec_w),
        .erasing   (erasing_w)
    );
endmodule

// File: rtl/nor_flash_emu_checker.sv
module nor_flash_emu_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic erasing,
    input logic erase_go,
    input logic prog_go,
    input logic wren_set,
    input logic wel,
    input logic miso,
    input logic sck_fall,
    input logic cs_rise
);
    assert_go_had_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_go || prog_go) |-> $past(wel));

    assert_wel_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_go || prog_go) |-> !wel);

    assert_one_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_set, erase_go, prog_go}));

    assert_go_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_go || prog_go) |-> !busy);

    assert_busy_follows_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_go || prog_go) |=> busy);

    assert_busy_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(erase_go || prog_go));

    assert_erase_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> busy);

    assert_miso_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sck_fall || cs_rise));
endmodule

bind nor_flash_emu nor_flash_emu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .erasing  (erasing_w),
    .erase_go (erase_go_w),
    .prog_go  (prog_go_w),
    .wren_set (wren_set_w),
    .wel      (wel_w),
    .miso     (miso),
    .sck_fall (sck_fall_w),
    .cs_rise  (cs_rise_w)
);

// File: tb/nor_flash_emu_test.sv
`timescale 1ns/1ps
module nor_flash_emu_test;
    localparam int ERASE_CYC = 3000;
    localparam int PROG_CYC  = 1000;
    localparam int MIN_GAP   = 25;
    localparam int HP        = 8;   // system clocks per serial half period
    localparam int GAP       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [64];
    logic [7:0] rbuf [8];

    always #2 clk = ~clk;

    nor_flash_emu #(
        .SEC_W (2), .PG_W (1), .BY_W (3),
        .ERASE_CYC (ERASE_CYC), .PROG_CYC (PROG_CYC), .MIN_CS_HIGH (MIN_GAP)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .mosi (mosi), .miso (miso)
    );

    // R11 field mapping: sector bits 17:16, page bit 8, byte bits 2:0
    function automatic int bidx(input logic [23:0] a);
        return int'({a[17:16], a[8], a[2:0]});
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, expv);
        end
    endtask

    task automatic xfer(input logic [7:0] txb, output logic [7:0] rxb);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0;
            mosi = txb[i];
            repeat (HP) @(negedge clk);
            rxb[i] = miso;
            sck = 1'b1;
            repeat (HP - 1) @(negedge clk);
        end
    endtask

    task automatic sel_low();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic sel_high(input int gap);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_wren(input int gap);
        logic [7:0] d;
        sel_low();
        xfer(8'h06, d);
        sel_high(gap);
    endtask

    task automatic send_prog(input logic [23:0] a, input logic [7:0] v, input bit extra);
        logic [7:0] d;
        sel_low();
        xfer(8'h02, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        xfer(v, d);
        if (extra) xfer(v, d);
        sel_high(GAP);
    endtask

    task automatic send_erase(input logic [23:0] a);
        logic [7:0] d;
        sel_low();
        xfer(8'hD8, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        sel_high(GAP);
    endtask

    task automatic read_n(input logic [23:0] a, input int n);
        logic [7:0] d;
        sel_low();
        xfer(8'h03, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            rbuf[k] = d;
        end
        sel_high(GAP);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_prog(input logic [23:0] a, input logic [7:0] v);
        send_wren(GAP);
        send_prog(a, v, 1'b0);
        exp_mem[bidx(a)] = exp_mem[bidx(a)] & v;
        wait_cyc(PROG_CYC + 60);
    endtask

    task automatic t_reset();
        chk("R1", "miso after reset", {7'd0, miso}, 8'h01);
        read_n(24'h000000, 4);
        for (int k = 0; k < 4; k++) chk("R1", "fresh array byte", rbuf[k], 8'hFF);
        chk("R1", "miso idle after read", {7'd0, miso}, 8'h01);
    endtask

    task automatic t_prog_no_wren();
        send_prog(24'h000002, 8'h00, 1'b0);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h000002, 1);
        chk("R4", "program without latch", rbuf[0], 8'hFF);
    endtask

    task automatic t_program();
        do_prog(24'h010105, 8'hA5);
        read_n(24'h010105, 1);
        chk("R5", "programmed byte msb-first", rbuf[0], 8'hA5);
        chk("R3", "latch armed program", rbuf[0], exp_mem[29]);
        do_prog(24'h010105, 8'h3C);
        read_n(24'h010105, 1);
        chk("R5", "second program ANDs", rbuf[0], 8'h24);
    endtask

    task automatic t_wel_clear();
        send_prog(24'h010105, 8'h00, 1'b0);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h010105, 1);
        chk("R8", "latch cleared after program", rbuf[0], 8'h24);
    endtask

    task automatic t_frame_len();
        send_wren(GAP);
        send_prog(24'h010105, 8'h00, 1'b1);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h010105, 1);
        chk("R8", "overlong program frame ignored", rbuf[0], 8'h24);
        send_prog(24'h010105, 8'h04, 1'b0);
        exp_mem[29] = exp_mem[29] & 8'h04;
        wait_cyc(PROG_CYC + 60);
        read_n(24'h010105, 1);
        chk("R8", "latch kept after rejected frame", rbuf[0], exp_mem[29]);
    endtask

    task automatic t_wrap();
        do_prog(24'h030106, 8'h11);
        do_prog(24'h030107, 8'h22);
        do_prog(24'h000000, 8'h33);
        read_n(24'h030106, 4);
        chk("R7", "stream byte 0", rbuf[0], 8'h11);
        chk("R7", "stream byte 1", rbuf[1], 8'h22);
        chk("R7", "stream wraps to 0", rbuf[2], 8'h33);
        chk("R7", "stream byte after wrap", rbuf[3], 8'hFF);
    endtask

    task automatic t_erase();
        do_prog(24'h020000, 8'h5A);
        send_wren(GAP);
        send_erase(24'h0101FF);   // R6: page/byte fields set, must be ignored
        for (int k = 16; k < 32; k++) exp_mem[k] = 8'hFF;
        wait_cyc(ERASE_CYC + 60);
        read_n(24'h010105, 1);
        chk("R6", "erased byte in sector 1", rbuf[0], 8'hFF);
        read_n(24'h010000, 1);
        chk("R6", "sector 1 first byte", rbuf[0], 8'hFF);
        read_n(24'h020000, 1);
        chk("R6", "sector 2 untouched", rbuf[0], 8'h5A);
        read_n(24'h000000, 1);
        chk("R6", "sector 0 untouched", rbuf[0], 8'h33);
        // R11: upper address bits do not select storage
        read_n(24'hF2FE00, 1);
        chk("R11", "aliased address", rbuf[0], 8'h5A);
    endtask

    task automatic t_busy();
        send_wren(GAP);
        send_prog(24'h020001, 8'h00, 1'b0);
        read_n(24'h020001, 1);
        chk("R9", "read during program busy", rbuf[0], 8'hFF);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h020001, 1);
        chk("R9", "read after program busy", rbuf[0], 8'h00);
        send_wren(GAP);
        send_erase(24'h030000);
        wait_cyc(PROG_CYC + 100);
        read_n(24'h020001, 1);
        chk("R9", "read inside longer erase busy", rbuf[0], 8'hFF);
        wait_cyc(ERASE_CYC);
        read_n(24'h020001, 1);
        chk("R9", "read after erase busy", rbuf[0], 8'h00);
        read_n(24'h030106, 1);
        chk("R6", "sector 3 erased", rbuf[0], 8'hFF);
    endtask

    task automatic t_gap();
        send_wren(5);
        send_prog(24'h020002, 8'h77, 1'b0);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h020002, 1);
        chk("R10", "frame after short gap ignored", rbuf[0], 8'hFF);
        send_prog(24'h020002, 8'h77, 1'b0);
        wait_cyc(PROG_CYC + 60);
        read_n(24'h020002, 1);
        chk("R10", "normal gap frame accepted", rbuf[0], 8'h77);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) exp_mem[k] = 8'hFF;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_prog_no_wren();
        t_program();
        t_wel_clear();
        t_frame_len();
        t_wrap();
        t_erase();
        t_busy();
        t_gap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule